// File: doc/BRIEF.md
# Dual Hit Finder Scanner

This block walks through rows of per-channel samples taken from a row queue. Each queued row holds one hit flag and one data word per channel. Once a row is loaded, the scanner removes up to two flagged channels from it in every cycle. The lower-numbered of the two goes to output lane A and the higher-numbered one goes to lane B. Each lane carries its own channel number, data word and valid bit. In the same cycle as each hand-over, the channel numbers go out on two hit-RAM write lanes. The write addresses are the running hit index within the row.

A controller built around three named states sequences the work. FETCH holds the queue-ready signal high and waits for a row. FETCH goes to SCAN when the row has at least one flag, and to DONE when the row has none. SCAN presents the current pair and clears the served channels from a working mask whenever the consumer takes the pair. SCAN goes to DONE in the cycle that takes the last pending hit. DONE pulses the row-complete signal with the row's hit total, then returns to FETCH. When the consumer holds the output ready signal low, SCAN stays where it is and the presented pair does not change.

Top module: `hfs_scanner`

## Requirements
- R1: After reset, in_ready is 1, a_valid, b_valid and row_done are 0, and neither hit-RAM write enable is asserted.
- R2: In SCAN, a_valid is 1, a_chan is the lowest channel index still pending in the loaded row, and a_data is that channel's data word, taken from bits [chan*DW +: DW] of in_data.
- R3: b_valid is 1 only when at least two channels are pending. In that case b_chan is the second-lowest pending index, which is always greater than a_chan, and b_data is that channel's word.
- R4: A transfer happens when out_ready is 1 while a_valid is 1. After a transfer, the served channels are never presented again, and the next cycle presents the next pair in ascending order.
- R5: While out_ready is 0, the valids, channels and data of both lanes stay unchanged, and no hit-RAM write happens.
- R6: On each transfer, lane A writes a_chan at address k, where k is the number of hits already taken from this row. When b_valid is 1, lane B writes b_chan at address k+1 in the same cycle.
- R7: The cycle after the last hit of a row is taken, row_done is 1 for exactly one cycle and row_hits equals the row's flag count. in_ready is 1 in the cycle that follows.
- R8: A row with no flags is accepted and gives row_done=1 with row_hits=0 in the next cycle. It produces no valid output and no hit-RAM write.
- R9: in_ready is 0 from the cycle after a row is accepted until that row's row_done cycle is over.
- R10: A row with all NCH channels flagged finishes in NCH/2 transfers and reports row_hits=NCH. With the default of 128 this is reported as 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row queue has a row |
| in_ready | output | 1 | Scanner takes the row (queue pop) |
| in_flags | input | NCH | Hit flag per channel |
| in_data | input | NCH*DW | Data word per channel, channel c at [c*DW +: DW] |
| out_ready | input | 1 | Consumer takes the presented pair |
| a_valid | output | 1 | Lane A holds a hit |
| a_chan | output | CW | Lane A channel index |
| a_data | output | DW | Lane A data word |
| b_valid | output | 1 | Lane B holds a hit |
| b_chan | output | CW | Lane B channel index |
| b_data | output | DW | Lane B data word |
| ram_we_a | output | 1 | Hit-RAM write, lane A |
| ram_addr_a | output | CW | Hit-RAM address, lane A |
| ram_pos_a | output | CW | Position written, lane A |
| ram_we_b | output | 1 | Hit-RAM write, lane B |
| ram_addr_b | output | CW | Hit-RAM address, lane B |
| ram_pos_b | output | CW | Position written, lane B |
| row_done | output | 1 | Row finished (one-cycle pulse) |
| row_hits | output | HW | Hit total of the finished row |

## Verification
The bench targets the two ends of the channel range, channel 0 and channel 127. A priority encoder with the wrong direction would swap the two lanes, and an off-by-one mask clear would repeat a channel or skip one. It uses rows with an odd hit count, so the last transfer uses lane A alone. A design that raises b_valid there would write a stale position to the hit RAM. It holds out_ready low partway through a row. A design that advanced on a stall would lose hits or write during the stall. It also sends an empty row and a fully flagged row. A wrong count width would wrap 128 to 0, and a design that took the empty path through SCAN would add a cycle or raise a valid output.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DONE  = 2'd2
    } hfs_state_e;
endpackage

// File: rtl/hfs_lsb_find.sv
module hfs_lsb_find #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hfs_pick2.sv
module hfs_pick2 #(
    parameter int N = 128,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vec,
    output logic          found0,
    output logic [IW-1:0] idx0,
    output logic          found1,
    output logic [IW-1:0] idx1
);
    logic [N-1:0] rest;

    hfs_lsb_find #(.N(N)) u_first (
        .vec  (vec),
        .found(found0),
        .idx  (idx0)
    );

    assign rest = vec & ~(N'(1) << idx0);

    hfs_lsb_find #(.N(N)) u_second (
        .vec  (rest),
        .found(found1),
        .idx  (idx1)
    );

    // R3: second pick only exists with a first one, and lies above it
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        found1 |-> (found0 && (idx1 > idx0)));
endmodule

// File: rtl/hfs_payload_mux.sv
module hfs_payload_mux #(
    parameter int N  = 128,
    parameter int DW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N*DW-1:0] words,
    input  logic [IW-1:0]   sel,
    output logic [DW-1:0]   word
);
    assign word = words[sel*DW +: DW];
endmodule

// File: rtl/hfs_scanner.sv
module hfs_scanner
    import hfs_pkg::*;
#(
    parameter int NCH = 128,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH),
    localparam int HW = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NCH-1:0]    in_flags,
    input  logic [NCH*DW-1:0] in_data,
    input  logic              out_ready,
    output logic              a_valid,
    output logic [CW-1:0]     a_chan,
    output logic [DW-1:0]     a_data,
    output logic              b_valid,
    output logic [CW-1:0]     b_chan,
    output logic [DW-1:0]     b_data,
    output logic              ram_we_a,
    output logic [CW-1:0]     ram_addr_a,
    output logic [CW-1:0]     ram_pos_a,
    output logic              ram_we_b,
    output logic [CW-1:0]     ram_addr_b,
    output logic [CW-1:0]     ram_pos_b,
    output logic              row_done,
    output logic [HW-1:0]     row_hits
);
    hfs_state_e st_q, st_d;

    logic [NCH-1:0]    mask_q;
    logic [NCH*DW-1:0] data_q;
    logic [HW-1:0]     cnt_q;

    logic          f0, f1;
    logic [CW-1:0] i0, i1;
    logic          take;
    logic [NCH-1:0] served;
    logic [NCH-1:0] mask_nx;

    hfs_pick2 #(.N(NCH)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (mask_q),
        .found0(f0),
        .idx0  (i0),
        .found1(f1),
        .idx1  (i1)
    );

    logic [CW-1:0] lane_sel [2];
    logic [DW-1:0] lane_word [2];
    assign lane_sel[0] = i0;
    assign lane_sel[1] = i1;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        hfs_payload_mux #(.N(NCH), .DW(DW)) u_mux (
            .words(data_q),
            .sel  (lane_sel[g]),
            .word (lane_word[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FETCH;
        else        st_q <= st_d;
    end

    // served channels and next state
    always_comb begin
        take    = (st_q == ST_SCAN) && f0 && out_ready;
        served  = '0;
        if (take) begin
            served = served | (NCH'(1) << i0);
            if (f1) served = served | (NCH'(1) << i1);
        end
        mask_nx = mask_q & ~served;
        st_d    = st_q;
        unique case (st_q)
            ST_FETCH: if (in_valid) st_d = (|in_flags) ? ST_SCAN : ST_DONE;
            ST_SCAN:  if (take && (mask_nx == '0)) st_d = ST_DONE;
            ST_DONE:  st_d = ST_FETCH;
            default:  st_d = ST_FETCH;
        endcase
    end

    // working mask and hit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (st_q == ST_FETCH && in_valid) begin
            mask_q <= in_flags;
            cnt_q  <= '0;
        end else if (take) begin
            mask_q <= mask_nx;
            cnt_q  <= cnt_q + (f1 ? HW'(2) : HW'(1));
        end
    end

    // sample payloads, captured with the row
    always_ff @(posedge clk) begin
        if (st_q == ST_FETCH && in_valid) data_q <= in_data;
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        row_done   = 1'b0;
        a_valid    = 1'b0;
        b_valid    = 1'b0;
        unique case (st_q)
            ST_FETCH: in_ready = 1'b1;
            ST_SCAN: begin
                a_valid = f0;
                b_valid = f1;
            end
            ST_DONE:  row_done = 1'b1;
            default:  in_ready = 1'b0;
        endcase
        a_chan     = i0;
        b_chan     = i1;
        a_data     = lane_word[0];
        b_data     = lane_word[1];
        row_hits   = cnt_q;
        ram_we_a   = a_valid && out_ready;
        ram_we_b   = b_valid && out_ready;
        ram_addr_a = cnt_q[CW-1:0];
        ram_addr_b = CW'(cnt_q + HW'(1));
        ram_pos_a  = i0;
        ram_pos_b  = i1;
    end

    // R5: a stalled pair is presented again unchanged
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !out_ready) |=> (a_valid && $stable(a_chan) &&
                                     $stable(b_valid) && $stable(b_chan)));

    // R4: a channel handed over on lane A is not presented again
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_a |=> !(a_valid && a_chan == $past(a_chan)));

    // R7: row completion lasts one cycle and is followed by readiness
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> (!row_done && in_ready));

    // R9: no further row is accepted right after one is taken
    a_r9_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: an empty row goes straight to completion with zero hits
    a_r8_empty_row: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_flags == '0) |=>
            (row_done && row_hits == '0 && !a_valid));
endmodule

// File: tb/tb_hfs_scanner.sv
module tb_hfs_scanner;
    localparam int NCH = 128;
    localparam int DW  = 8;
    localparam int CW  = $clog2(NCH);
    localparam int HW  = $clog2(NCH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [NCH-1:0]    in_flags = '0;
    logic [NCH*DW-1:0] in_data = '0;
    logic              out_ready = 1'b1;
    logic              a_valid, b_valid;
    logic [CW-1:0]     a_chan, b_chan;
    logic [DW-1:0]     a_data, b_data;
    logic              ram_we_a, ram_we_b;
    logic [CW-1:0]     ram_addr_a, ram_addr_b, ram_pos_a, ram_pos_b;
    logic              row_done;
    logic [HW-1:0]     row_hits;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    hfs_scanner #(.NCH(NCH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_flags(in_flags), .in_data(in_data),
        .out_ready(out_ready),
        .a_valid(a_valid), .a_chan(a_chan), .a_data(a_data),
        .b_valid(b_valid), .b_chan(b_chan), .b_data(b_data),
        .ram_we_a(ram_we_a), .ram_addr_a(ram_addr_a), .ram_pos_a(ram_pos_a),
        .ram_we_b(ram_we_b), .ram_addr_b(ram_addr_b), .ram_pos_b(ram_pos_b),
        .row_done(row_done), .row_hits(row_hits)
    );

    function automatic logic [DW-1:0] word_of(input int c, input int seed);
        return DW'(c * 37 + seed * 11 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                report();
            end
        end
    end

    // one row: load, walk every pair, check completion
    task automatic run_row(input logic [NCH-1:0] fl, input int seed,
                           input bit stall_en, input string tag);
        int pend[$];
        int idx = 0;
        int cyc = 0;
        for (int c = 0; c < NCH; c++) if (fl[c]) pend.push_back(c);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_flags = fl;
        for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = word_of(c, seed);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (idx < pend.size()) begin
            bit stall = stall_en && (cyc % 3 == 1);
            bit two = (idx + 1 < pend.size());
            out_ready = !stall;
            #1;
            chk(in_ready == 1'b0, {"R9 ", tag}, int'(in_ready), 0);
            chk(a_valid && a_chan == CW'(pend[idx]), {"R2 chan ", tag}, int'(a_chan), pend[idx]);
            chk(a_data == word_of(pend[idx], seed), {"R2 data ", tag}, int'(a_data),
                int'(word_of(pend[idx], seed)));
            chk(b_valid == two, {"R3 valid ", tag}, int'(b_valid), int'(two));
            if (two) begin
                chk(b_chan == CW'(pend[idx+1]), {"R3 chan ", tag}, int'(b_chan), pend[idx+1]);
                chk(b_data == word_of(pend[idx+1], seed), {"R3 data ", tag}, int'(b_data),
                    int'(word_of(pend[idx+1], seed)));
            end
            if (stall) begin
                chk(!ram_we_a && !ram_we_b, {"R5 stall write ", tag},
                    int'(ram_we_a) + int'(ram_we_b), 0);
            end else begin
                chk(ram_we_a && ram_addr_a == CW'(idx) && ram_pos_a == CW'(pend[idx]),
                    {"R6 lane A ", tag}, int'(ram_addr_a), idx);
                chk(ram_we_b == two, {"R6 lane B enable ", tag}, int'(ram_we_b), int'(two));
                if (two)
                    chk(ram_addr_b == CW'(idx + 1) && ram_pos_b == CW'(pend[idx+1]),
                        {"R6 lane B ", tag}, int'(ram_addr_b), idx + 1);
                idx += 2;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk(row_done == 1'b1, {"R7 R8 done ", tag}, int'(row_done), 1);
        chk(row_hits == HW'(pend.size()), {"R7 R10 hits ", tag}, int'(row_hits), pend.size());
        chk(!a_valid && !ram_we_a && !ram_we_b, {"R8 quiet at done ", tag}, int'(a_valid), 0);
        @(negedge clk);
        #1;
        chk(row_done == 1'b0 && in_ready == 1'b1, {"R7 pulse end ", tag}, int'(row_done), 0);
    endtask

    task automatic t_reset;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(!a_valid && !b_valid, "R1 valids", int'(a_valid) + int'(b_valid), 0);
        chk(!row_done, "R1 row_done", int'(row_done), 0);
        chk(!ram_we_a && !ram_we_b, "R1 writes", int'(ram_we_a) + int'(ram_we_b), 0);
    endtask

    task automatic t_sparse;
        logic [NCH-1:0] f = '0;
        f[3] = 1'b1; f[10] = 1'b1; f[77] = 1'b1;
        run_row(f, 1, 1'b0, "sparse odd R4");
    endtask

    task automatic t_edges;
        logic [NCH-1:0] f = '0;
        f[0] = 1'b1; f[1] = 1'b1; f[64] = 1'b1; f[127] = 1'b1;
        run_row(f, 2, 1'b0, "edge channels");
    endtask

    task automatic t_empty;
        run_row('0, 3, 1'b0, "empty R8");
    endtask

    task automatic t_single;
        logic [NCH-1:0] f = '0;
        f[127] = 1'b1;
        run_row(f, 4, 1'b0, "single top");
    endtask

    task automatic t_stall;
        logic [NCH-1:0] f = '0;
        for (int c = 5; c < NCH; c += 9) f[c] = 1'b1;
        run_row(f, 5, 1'b1, "stalled R5");
    endtask

    task automatic t_full;
        run_row('1, 6, 1'b1, "full R10");
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sparse();
        t_edges();
        t_empty();
        t_single();
        t_stall();
        t_full();
        t_empty();
        report();
    end
endmodule